// File: doc/BRIEF.md
# HDB3 Line Codec with Coding-Violation Flagging

This block sits between a framer and a line interface running at E2 or E3 rate. On the transmit side it turns a single-rail NRZ bit stream into a pair of positive and negative pulse rails that follow HDB3 coding. On the receive side it turns the pulse rails back into NRZ data. It also emits a one-clock pulse for every bipolar violation that cannot belong to a legal zero-substitution group. A mode input can bypass both codec paths, so that raw positive/negative rail data passes straight through in both directions.

Either direction can be overridden with an all-ones alarm pattern. Two diagnostic loopbacks are provided. One returns line receive data to the line transmit output. The other feeds the block's own line transmit output into its receive path. Everything runs on a single rising-edge clock. Every output is registered.

On the line rails, a positive pulse is `p=1,n=0`, a negative pulse is `p=0,n=1`, and a zero is both rails low. Both rails high is illegal.

Top module: `hdb3_codec_top`

## Requirements
- R1: With `nrz_mode`=0, and with both alarm inputs and both loopback inputs high, `line_tx_p/n` equal `term_tx_p/n`, and `term_rx_p/n` equal `line_rx_p/n`, each one clock after sampling. `cv_o` stays 0.
- R2: With `nrz_mode`=1, `term_rx_n` is held at 0 and `term_tx_n` has no effect on any output.
- R3: With `nrz_mode`=1, each NRZ bit on `term_tx_p` appears as an HDB3 symbol on `line_tx_p/n` four clocks after the clock that samples it.
  - Ordinary marks alternate in polarity.
  - Each group of four zeros becomes 000V when an odd number of pulses has been sent since the last V, and B00V when that number is even.
  - B alternates like an ordinary mark. V repeats the polarity of the pulse before it.
- R4: In NRZ mode with receive loopback off, `line_tx_p/n` never shows more than three consecutive zero symbols once the pipeline has filled. The two rails are never high together.
- R5: With `nrz_mode`=1, a legal HDB3 stream on `line_rx_p/n` is restored to its NRZ bits on `term_rx_p`, four clocks after the clock that samples each symbol. `cv_o` stays 0 for such a stream.
- R6: With `nrz_mode`=1, `cv_o` pulses high for one clock, one clock after a symbol is sampled, in either of two cases.
  - The symbol has both rails high.
  - The symbol is a pulse of the same polarity as the previous pulse, and either it matches the polarity of the previous such violation, or one of the two symbols before it is a pulse.
  - In P/N mode `cv_o` is 0.
- R7: With `tx_ais_n`=0, the transmit encoder is fed all ones in both modes, whatever the terminal transmit data. `line_tx_p/n` therefore carries alternating pulses, with the first pulse positive, after the four-clock encoder delay.
- R8: With `rx_ais_n`=0, the line receive input is ignored and `cv_o` is 0.
  - In NRZ mode `term_rx_p`=1 and `term_rx_n`=0.
  - In P/N mode `term_rx_p/n` are complementary and toggle every clock.
- R9: With `rx_loop_n`=0 and `tx_ais_n`=1, `line_tx_p/n` equal `line_rx_p/n` one clock later, and terminal transmit input is ignored. The receive terminal output keeps decoding the line.
- R10: With `tx_loop_n`=0, the receive path takes `line_tx_p/n` instead of `line_rx_p/n`. In NRZ mode, `term_rx_p` reproduces `term_tx_p` nine clocks after it is sampled.
- R11: After reset all outputs are 0. The first transmitted pulse is positive, and the first four-zero group is coded B00V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nrz_mode | input | 1 | 1: NRZ terminal data with codec active; 0: raw P/N rails, codec bypassed |
| tx_ais_n | input | 1 | Active-low all-ones insertion toward the line |
| rx_ais_n | input | 1 | Active-low all-ones insertion toward the terminal |
| rx_loop_n | input | 1 | Active-low loop of line receive data to line transmit |
| tx_loop_n | input | 1 | Active-low loop of line transmit data into the receive path |
| term_tx_p | input | 1 | Terminal transmit NRZ data, or positive rail in P/N mode |
| term_tx_n | input | 1 | Terminal transmit negative rail (P/N mode only) |
| line_rx_p | input | 1 | Line receive positive pulse rail |
| line_rx_n | input | 1 | Line receive negative pulse rail |
| line_tx_p | output | 1 | Line transmit positive pulse rail |
| line_tx_n | output | 1 | Line transmit negative pulse rail |
| term_rx_p | output | 1 | Terminal receive NRZ data, or positive rail in P/N mode |
| term_rx_n | output | 1 | Terminal receive negative rail, 0 in NRZ mode |
| cv_o | output | 1 | One-clock coding-violation pulse |

## Verification
The encoder keeps a polarity bit and a pulse-parity bit. A wrong value in either shows up on the line rails at the next pulse or the next four-zero group, at most a few symbols later. A wrong decoder polarity or violation history shows up as a spurious or missing `cv_o` pulse in the clock after the next pulse. A slot that is not cleared shows up as a stray one on `term_rx_p` four clocks later. The sweeps therefore compare every symbol and every clock against a sequential model of the line code. The sweeps cover every 10-bit transmit pattern, single-symbol corruptions of legal streams, and every alarm and loopback mode.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // Window length of the zero-substitution group; the lookahead depth of both paths.
  localparam int WIN = 4;

  // Transmit symbol kinds held in the encoder window.
  typedef enum logic [2:0] {
    SYM_IDLE,  // post-reset filler: emitted as zero, never part of a group
    SYM_ZERO,
    SYM_MARK,
    SYM_BSUB,
    SYM_VSUB
  } sym_e;
endpackage

// File: rtl/hdb3_encoder.sv
module hdb3_encoder
  import hdb3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic mark_o,
  output logic pos_o
);
  sym_e slot_q [WIN];
  sym_e slot_d [WIN];
  sym_e head;
  logic last_pos_q;
  logic odd_q, odd_d;
  logic run_zero;

  always_comb begin
    head   = slot_q[WIN-1];
    mark_o = (head == SYM_MARK) || (head == SYM_BSUB) || (head == SYM_VSUB);
    // V repeats the last polarity; MARK and B alternate.
    pos_o  = (head == SYM_VSUB) ? last_pos_q : ~last_pos_q;
    odd_d  = odd_q;
    if (head == SYM_VSUB) odd_d = 1'b0;
    else if (mark_o)      odd_d = ~odd_q;

    run_zero = ~bit_in;
    for (int i = 0; i < WIN-1; i++) begin
      if (slot_q[i] != SYM_ZERO) run_zero = 1'b0;
    end

    slot_d[0] = bit_in ? SYM_MARK : SYM_ZERO;
    for (int i = 1; i < WIN; i++) slot_d[i] = slot_q[i-1];
    if (run_zero) begin
      slot_d[0] = SYM_VSUB;
      if (!odd_d) slot_d[WIN-1] = SYM_BSUB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) slot_q[i] <= SYM_IDLE;
      last_pos_q <= 1'b0;
      odd_q      <= 1'b0;
    end else begin
      for (int i = 0; i < WIN; i++) slot_q[i] <= slot_d[i];
      if (mark_o) last_pos_q <= pos_o;
      odd_q <= odd_d;
    end
  end
endmodule

// File: rtl/hdb3_decoder.sv
module hdb3_decoder
  import hdb3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_p,
  input  logic in_n,
  output logic data_o,
  output logic cv_o
);
  logic [WIN-1:0] data_q, data_d;
  logic [WIN-2:0] raw_q, raw_d;   // raw pulse history, before any clearing
  logic last_pos_q, seen_q, v_seen_q, v_pos_q;
  logic mark, is_v, gap_bad;

  always_comb begin
    mark    = in_p ^ in_n;
    is_v    = mark && seen_q && (in_p == last_pos_q);
    gap_bad = |raw_q[WIN-3:0];
    cv_o    = (in_p & in_n) |
              (is_v & (gap_bad | (v_seen_q & (in_p == v_pos_q))));
    data_d  = {data_q[WIN-2:0], mark & ~is_v};
    raw_d   = {raw_q[WIN-3:0], mark};
    // A pulse three symbols before a V is the B of a B00V group.
    if (is_v && raw_q[WIN-2]) data_d[WIN-1] = 1'b0;
    data_o  = data_q[WIN-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      raw_q      <= '0;
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
      v_seen_q   <= 1'b0;
      v_pos_q    <= 1'b0;
    end else begin
      data_q <= data_d;
      raw_q  <= raw_d;
      if (mark) begin
        last_pos_q <= in_p;
        seen_q     <= 1'b1;
      end
      if (is_v) begin
        v_seen_q <= 1'b1;
        v_pos_q  <= in_p;
      end
    end
  end
endmodule

// File: rtl/hdb3_codec_top.sv
module hdb3_codec_top (
  input  logic clk,
  input  logic rst,
  input  logic nrz_mode,
  input  logic tx_ais_n,
  input  logic rx_ais_n,
  input  logic rx_loop_n,
  input  logic tx_loop_n,
  input  logic term_tx_p,
  input  logic term_tx_n,
  input  logic line_rx_p,
  input  logic line_rx_n,
  output logic line_tx_p,
  output logic line_tx_n,
  output logic term_rx_p,
  output logic term_rx_n,
  output logic cv_o
);
  logic rx_src_p, rx_src_n;
  logic enc_in, enc_mark, enc_pos;
  logic dec_data, dec_cv;
  logic ais_tgl;

  always_comb begin
    rx_src_p = tx_loop_n ? line_rx_p : line_tx_p;
    rx_src_n = tx_loop_n ? line_rx_n : line_tx_n;
    enc_in   = ~tx_ais_n | term_tx_p;
  end

  hdb3_encoder enc_i (
    .clk(clk), .rst(rst), .bit_in(enc_in), .mark_o(enc_mark), .pos_o(enc_pos)
  );

  hdb3_decoder dec_i (
    .clk(clk), .rst(rst),
    .in_p(rx_src_p & rx_ais_n), .in_n(rx_src_n & rx_ais_n),
    .data_o(dec_data), .cv_o(dec_cv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx_p <= 1'b0;
      line_tx_n <= 1'b0;
      term_rx_p <= 1'b0;
      term_rx_n <= 1'b0;
      cv_o      <= 1'b0;
      ais_tgl   <= 1'b0;
    end else begin
      if (!tx_ais_n || (rx_loop_n && nrz_mode)) begin
        line_tx_p <= enc_mark & enc_pos;
        line_tx_n <= enc_mark & ~enc_pos;
      end else if (!rx_loop_n) begin
        line_tx_p <= rx_src_p;
        line_tx_n <= rx_src_n;
      end else begin
        line_tx_p <= term_tx_p;
        line_tx_n <= term_tx_n;
      end

      if (!rx_ais_n) begin
        term_rx_p <= nrz_mode ? 1'b1 : ais_tgl;
        term_rx_n <= nrz_mode ? 1'b0 : ~ais_tgl;
      end else if (nrz_mode) begin
        term_rx_p <= dec_data;
        term_rx_n <= 1'b0;
      end else begin
        term_rx_p <= rx_src_p;
        term_rx_n <= rx_src_n;
      end

      ais_tgl <= (!rx_ais_n && !nrz_mode) ? ~ais_tgl : 1'b0;
      cv_o    <= nrz_mode & rx_ais_n & dec_cv;
    end
  end
endmodule

// File: rtl/hdb3_codec_chk.sv
module hdb3_codec_chk #(
  parameter int WARM = 12
) (
  input logic clk,
  input logic rst,
  input logic nrz_mode,
  input logic rx_ais_n,
  input logic rx_loop_n,
  input logic line_tx_p,
  input logic line_tx_n,
  input logic term_rx_p,
  input logic term_rx_n,
  input logic cv_o
);
  localparam int WW = $clog2(WARM + 2);
  localparam logic [WW-1:0] WMAX = '1;

  logic [2:0]    zero_run;
  logic [WW-1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_run <= '0;
      warm     <= '0;
    end else begin
      zero_run <= (line_tx_p | line_tx_n) ? 3'd0 :
                  ((zero_run == 3'd7) ? 3'd7 : zero_run + 3'd1);
      warm     <= (nrz_mode && rx_loop_n) ?
                  ((warm == WMAX) ? WMAX : warm + 1'b1) : '0;
    end
  end

  // R4: encoder output never runs four zeros once filled
  p_zero_run_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(warm) >= WARM) |-> (zero_run < 3'd4));

  // R4: encoded rails are never both high
  p_tx_rails_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $past(nrz_mode && rx_loop_n) |-> !(line_tx_p && line_tx_n));

  // R2: negative receive rail quiet in NRZ mode
  p_rx_n_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $past(nrz_mode) |-> !term_rx_n);

  // R6: no violation pulses in P/N mode
  p_cv_pn_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(nrz_mode) |-> !cv_o);

  // R8: receive alarm in NRZ mode gives ones and no violations
  p_rx_ais_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rx_ais_n && nrz_mode)) |-> (term_rx_p && !cv_o));
endmodule

bind hdb3_codec_top hdb3_codec_chk chk_i (
  .clk(clk), .rst(rst), .nrz_mode(nrz_mode), .rx_ais_n(rx_ais_n),
  .rx_loop_n(rx_loop_n), .line_tx_p(line_tx_p), .line_tx_n(line_tx_n),
  .term_rx_p(term_rx_p), .term_rx_n(term_rx_n), .cv_o(cv_o)
);

// File: tb/hdb3_codec_top_tb_top.sv
`timescale 1ns/1ps
module hdb3_codec_top_tb_top;
  localparam int RUN = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_mode = 1'b1, tx_ais_n = 1'b1, rx_ais_n = 1'b1, rx_loop_n = 1'b1, tx_loop_n = 1'b1;
  logic term_tx_p = 1'b0, term_tx_n = 1'b0, line_rx_p = 1'b0, line_rx_n = 1'b0;
  logic line_tx_p, line_tx_n, term_rx_p, term_rx_n, cv_o;

  always #5 clk = ~clk;

  hdb3_codec_top dut_i (
    .clk(clk), .rst(rst), .nrz_mode(nrz_mode), .tx_ais_n(tx_ais_n),
    .rx_ais_n(rx_ais_n), .rx_loop_n(rx_loop_n), .tx_loop_n(tx_loop_n),
    .term_tx_p(term_tx_p), .term_tx_n(term_tx_n),
    .line_rx_p(line_rx_p), .line_rx_n(line_rx_n),
    .line_tx_p(line_tx_p), .line_tx_n(line_tx_n),
    .term_rx_p(term_rx_p), .term_rx_n(term_rx_n), .cv_o(cv_o)
  );

  int tests = 0;
  int fails = 0;

  bit s_tp [RUN], s_tn [RUN], s_rp [RUN], s_rn [RUN];
  bit r_lp [RUN], r_ln [RUN], r_tp [RUN], r_tn [RUN], r_cv [RUN];
  bit m_in [RUN], m_p [RUN], m_n [RUN], e_cv [RUN];

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Sequential HDB3 reference: greedy four-zero groups, parity since last V.
  task automatic enc_model();
    int pol = -1;
    int cnt = 0;
    int k = 0;
    while (k < RUN) begin
      if (k + 3 < RUN && !m_in[k] && !m_in[k+1] && !m_in[k+2] && !m_in[k+3]) begin
        for (int q = 0; q < 4; q++) begin m_p[k+q] = 0; m_n[k+q] = 0; end
        if (cnt % 2 == 0) begin
          pol = -pol;
          m_p[k] = (pol > 0); m_n[k] = (pol < 0);
        end
        m_p[k+3] = (pol > 0); m_n[k+3] = (pol < 0);
        cnt = 0;
        k += 4;
      end else if (m_in[k]) begin
        pol = -pol;
        m_p[k] = (pol > 0); m_n[k] = (pol < 0);
        cnt++;
        k++;
      end else begin
        m_p[k] = 0; m_n[k] = 0;
        k++;
      end
    end
  endtask

  // Violation reference over the raw line symbols s_rp/s_rn.
  task automatic cv_model();
    int lastpol = 0;
    int lastv = 0;
    for (int k = 0; k < RUN; k++) begin
      e_cv[k] = 0;
      if (s_rp[k] && s_rn[k]) e_cv[k] = 1;
      else if (s_rp[k] ^ s_rn[k]) begin
        int pol = s_rp[k] ? 1 : -1;
        if (pol == lastpol) begin
          e_cv[k] = (k >= 1 && (s_rp[k-1] ^ s_rn[k-1])) ||
                    (k >= 2 && (s_rp[k-2] ^ s_rn[k-2])) || (lastv == pol);
          lastv = pol;
        end
        lastpol = pol;
      end
    end
  endtask

  task automatic set_ctrl(bit nrz, bit tais, bit rais, bit rlp, bit tlp);
    nrz_mode = nrz; tx_ais_n = tais; rx_ais_n = rais; rx_loop_n = rlp; tx_loop_n = tlp;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    term_tx_p = 0; term_tx_n = 0; line_rx_p = 0; line_rx_n = 0;
    repeat (2) @(negedge clk);
  endtask

  // Index j: record outputs at negedge j, then drive stimulus j (sampled at the next rising edge).
  task automatic run();
    for (int j = 0; j < RUN; j++) begin
      if (j > 0) @(negedge clk);
      r_lp[j] = line_tx_p; r_ln[j] = line_tx_n;
      r_tp[j] = term_rx_p; r_tn[j] = term_rx_n; r_cv[j] = cv_o;
      if (j == 0) rst = 1'b0;
      term_tx_p = s_tp[j]; term_tx_n = s_tn[j];
      line_rx_p = s_rp[j]; line_rx_n = s_rn[j];
    end
  endtask

  task automatic load_pattern(int pat);
    for (int k = 0; k < RUN; k++) m_in[k] = (k < 10) ? pat[k] : ((k * 5 + pat) % 7 == 0);
  endtask

  initial begin
    // R3 R5 R2: every 10-bit pattern through encoder and decoder
    for (int pat = 0; pat < 1024; pat++) begin
      set_ctrl(1, 1, 1, 1, 1);
      load_pattern(pat);
      enc_model();
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = m_in[k]; s_tn[k] = 1'($urandom);
        s_rp[k] = m_p[k];  s_rn[k] = m_n[k];
      end
      do_reset();
      run();
      if (pat == 0) begin
        chk("R11 reset line_tx_p", r_lp[0], 0);
        chk("R11 reset line_tx_n", r_ln[0], 0);
        chk("R11 reset term_rx_p", r_tp[0], 0);
        chk("R11 reset cv_o", r_cv[0], 0);
        // all-zero start: first group is B00V with B positive
        chk("R11 first B positive", r_lp[5], 1);
        chk("R11 first V positive", r_lp[8], 1);
      end
      for (int j = 5; j < RUN; j++) begin
        chk("R3 line_tx_p", r_lp[j], m_p[j-5]);
        chk("R3 line_tx_n", r_ln[j], m_n[j-5]);
        chk("R5 term_rx_p", r_tp[j], m_in[j-5]);
        chk("R2 term_rx_n", r_tn[j], 0);
      end
      for (int j = 1; j < RUN; j++) chk("R5 cv_o quiet", r_cv[j], 0);
    end

    // R6: single-symbol corruptions of legal streams
    for (int pat = 0; pat < 256; pat++) begin
      int q = pat % 12 + 2;
      set_ctrl(1, 1, 1, 1, 1);
      load_pattern(pat * 3 + 1);
      enc_model();
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = 0; s_tn[k] = 0; s_rp[k] = m_p[k]; s_rn[k] = m_n[k];
      end
      if (pat % 16 == 15) begin s_rp[q] = 1; s_rn[q] = 1; end
      else if (s_rp[q] ^ s_rn[q]) begin s_rp[q] = ~s_rp[q]; s_rn[q] = ~s_rn[q]; end
      else begin s_rp[q] = pat[4]; s_rn[q] = ~pat[4]; end
      cv_model();
      do_reset();
      run();
      for (int k = 0; k < RUN-1; k++) chk("R6 cv_o", r_cv[k+1], e_cv[k]);
    end

    // R1 R6: P/N bypass
    for (int t = 0; t < 8; t++) begin
      set_ctrl(0, 1, 1, 1, 1);
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = 1'($urandom); s_tn[k] = 1'($urandom);
        s_rp[k] = 1'($urandom); s_rn[k] = 1'($urandom);
      end
      do_reset();
      run();
      for (int j = 1; j < RUN; j++) begin
        chk("R1 line_tx_p", r_lp[j], s_tp[j-1]);
        chk("R1 line_tx_n", r_ln[j], s_tn[j-1]);
        chk("R1 term_rx_p", r_tp[j], s_rp[j-1]);
        chk("R1 term_rx_n", r_tn[j], s_rn[j-1]);
        chk("R6 cv_o in P/N", r_cv[j], 0);
      end
    end

    // R7: transmit alarm in both modes
    for (int md = 0; md < 2; md++) begin
      set_ctrl(1'(md), 0, 1, 1, 1);
      for (int k = 0; k < RUN; k++) begin
        m_in[k] = 1; s_tp[k] = 1'($urandom); s_tn[k] = 1'($urandom);
        s_rp[k] = 0; s_rn[k] = 0;
      end
      enc_model();
      do_reset();
      run();
      for (int j = 5; j < RUN; j++) begin
        chk("R7 line_tx_p", r_lp[j], m_p[j-5]);
        chk("R7 line_tx_n", r_ln[j], m_n[j-5]);
      end
    end

    // R8: receive alarm in both modes, line carries violations
    for (int md = 0; md < 2; md++) begin
      set_ctrl(1'(md), 1, 0, 1, 1);
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = 0; s_tn[k] = 0; s_rp[k] = 1; s_rn[k] = (k % 3 == 0);
      end
      do_reset();
      run();
      for (int j = 1; j < RUN; j++) begin
        chk("R8 cv_o", r_cv[j], 0);
        if (md == 1) begin
          chk("R8 NRZ term_rx_p", r_tp[j], 1);
          chk("R8 NRZ term_rx_n", r_tn[j], 0);
        end else begin
          chk("R8 P/N complement", r_tp[j] ^ r_tn[j], 1);
          if (j >= 2) chk("R8 P/N toggle", r_tp[j] ^ r_tp[j-1], 1);
        end
      end
    end

    // R9: receive loopback, terminal still decodes
    for (int pat = 5; pat < 1024; pat += 97) begin
      set_ctrl(1, 1, 1, 0, 1);
      load_pattern(pat);
      enc_model();
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = 1'($urandom); s_tn[k] = 1'($urandom); s_rp[k] = m_p[k]; s_rn[k] = m_n[k];
      end
      do_reset();
      run();
      for (int j = 1; j < RUN; j++) begin
        chk("R9 line_tx_p", r_lp[j], s_rp[j-1]);
        chk("R9 line_tx_n", r_ln[j], s_rn[j-1]);
      end
      for (int j = 5; j < RUN; j++) chk("R9 term_rx_p", r_tp[j], m_in[j-5]);
    end

    // R10: transmit loopback, line input ignored
    for (int pat = 11; pat < 1024; pat += 89) begin
      set_ctrl(1, 1, 1, 1, 0);
      load_pattern(pat);
      enc_model();
      for (int k = 0; k < RUN; k++) begin
        s_tp[k] = m_in[k]; s_tn[k] = 0; s_rp[k] = 1'($urandom); s_rn[k] = 1'($urandom);
      end
      do_reset();
      run();
      for (int j = 5; j < RUN; j++) chk("R10 line_tx_p", r_lp[j], m_p[j-5]);
      for (int j = 10; j < RUN; j++) chk("R10 term_rx_p", r_tp[j], m_in[j-10]);
      for (int j = 1; j < RUN; j++) chk("R10 cv_o", r_cv[j], 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule